// File: doc/BRIEF.md
# Two-Core MESI Line Coherence Controller

This block keeps two private data caches coherent over a small shared write-back store. Each core has its own load/store request port. Each line in each private cache is in one of four states: Modified (dirty), Exclusive (owned and clean), Shared (clean, possibly also held by the other core) or Invalid (no data). A core may write a line only once it owns that line exclusively. When a store finds the line Shared or Invalid, the controller performs a read-for-ownership. This invalidates the other core's copy and, if that copy was dirty, first writes its data back to the shared store.

All coherence work goes through one home agent, which completes one transaction per cycle. When both cores present a request in the same cycle, a round-robin tie-break picks which one goes first. The other request waits with its valid held high and completes in the next cycle. This gives every line a single modification order: the value written by the second-granted core is the one every later load sees. On a read miss, the line fills as Exclusive if the other core holds it Invalid, and as Shared otherwise. In the Shared case, an owning peer is downgraded to Shared and its dirty data is written back.

Top module: `mesi_coherence_ctrl`

## Requirements
- R1: After reset, no response is pending, every line of both caches is Invalid, the shared store reads as zero, and core 0 holds tie-break priority.
- R2: A request is accepted in a cycle where its valid and ready are both high. Its response-valid is high for exactly the following cycle, on that core's port only, and at most one request is accepted per cycle.
- R3: When both cores present a request in the same cycle, only one is made ready. Priority alternates, so the core that lost a conflict wins the next one. The loser, holding its valid, is accepted in the next cycle.
- R4: A request presented while the other core is idle is made ready in the same cycle.
- R5: A store updates byte i (bits 8i+7 to 8i) of the line only when bit i of its byte-enable is set. The other bytes keep the line's latest coherent value.
- R6: A store's response data is the full line value after the merge.
- R7: A load returns the value of the most recent store to that address in grant order, whichever core made that store.
- R8: For two stores to one line that arrive in the same cycle, the second-granted data is what later loads from either core return.
- R9: A read miss while the other core holds the line Modified returns the dirty data.
- R10: A line is never Modified or Exclusive in one cache while it is valid in the other.
- R11: A read miss while the other core holds the line Invalid fills it as Exclusive, so a following store by the same core needs no invalidation and is seen by the other core's later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c0_req_valid | input | 1 | Core 0 request valid |
| c0_req_ready | output | 1 | Core 0 request accepted this cycle |
| c0_req_write | input | 1 | Core 0 store (1) or load (0) |
| c0_req_addr | input | ADDR_W | Core 0 line address |
| c0_req_wdata | input | DATA_W | Core 0 store data |
| c0_req_be | input | DATA_W/8 | Core 0 byte write enables |
| c0_rsp_valid | output | 1 | Core 0 response pulse |
| c0_rsp_data | output | DATA_W | Core 0 load data or merged store line |
| c1_req_valid | input | 1 | Core 1 request valid |
| c1_req_ready | output | 1 | Core 1 request accepted this cycle |
| c1_req_write | input | 1 | Core 1 store (1) or load (0) |
| c1_req_addr | input | ADDR_W | Core 1 line address |
| c1_req_wdata | input | DATA_W | Core 1 store data |
| c1_req_be | input | DATA_W/8 | Core 1 byte write enables |
| c1_rsp_valid | output | 1 | Core 1 response pulse |
| c1_rsp_data | output | DATA_W | Core 1 load data or merged store line |

## Verification
The bench builds the block with its defaults: ADDR_W of 3 (eight lines) and DATA_W of 32 (four byte lanes). Eight lines are few enough that the same addresses are hit repeatedly from both cores, so every state pair comes up: a dirty line stolen by a store, a dirty line downgraded by a read, and an Exclusive fill followed by a silent upgrade. Four byte lanes allow sparse enable masks, which show that unwritten bytes come from the peer's dirty copy. Both same-cycle stores and same-cycle loads are issued in turn, so the round-robin pointer is seen flipping in both directions and returning to core 0 after a reset.

// File: rtl/mesi_coh_pkg.sv
package mesi_coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;
endpackage

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] grant
);
  logic prio_q, prio_d, prio_en;

  always_comb begin
    prio_en = (req == 2'b11);
    prio_d  = ~prio_q;
    if (req == 2'b11) grant = prio_q ? 2'b10 : 2'b01;
    else              grant = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_q <= 1'b0;
    else if (prio_en) prio_q <= prio_d;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= 1); // R2
  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == 2'b00); // R2
  AST_RR_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 2'b11) |=> ((req != 2'b11) || (grant != $past(grant)))); // R3
endmodule

// File: rtl/mesi_priv_cache.sv
module mesi_priv_cache
  import mesi_coh_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output line_st_t          lk_state,
  output logic [DATA_W-1:0] lk_data,
  input  logic              upd_en,
  input  line_st_t          upd_state,
  input  logic              upd_data_en,
  input  logic [DATA_W-1:0] upd_data
);
  localparam int LINES = 1 << ADDR_W;

  line_st_t          st_q  [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  assign lk_state = st_q[lk_addr];
  assign lk_data  = dat_q[lk_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (upd_en) begin
      st_q[lk_addr] <= upd_state;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_data_en) dat_q[lk_addr] <= upd_data;
  end
endmodule

// File: rtl/mesi_home.sv
module mesi_home
  import mesi_coh_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             grant,
  input  logic                   op_write,
  input  logic [ADDR_W-1:0]      op_addr,
  input  logic [DATA_W-1:0]      op_wdata,
  input  logic [DATA_W/8-1:0]    op_be,
  input  line_st_t [1:0]         lk_state,
  input  logic [1:0][DATA_W-1:0] lk_data,
  output logic [1:0]             upd_en,
  output line_st_t [1:0]         upd_state,
  output logic [1:0]             upd_data_en,
  output logic [DATA_W-1:0]      upd_data,
  output logic [DATA_W-1:0]      rsp_data
);
  localparam int LINES = 1 << ADDR_W;
  localparam int BE_W  = DATA_W / 8;

  logic [DATA_W-1:0] mem_q [LINES];
  logic              mem_we;
  logic [DATA_W-1:0] mem_wd;
  logic              act, g, o;
  line_st_t          st_g, st_o;
  logic [DATA_W-1:0] old_line, merged;

  always_comb begin
    act  = |grant;
    g    = grant[1];
    o    = ~g;
    st_g = lk_state[g];
    st_o = lk_state[o];
    if (st_g != ST_I)      old_line = lk_data[g];
    else if (st_o == ST_M) old_line = lk_data[o];
    else                   old_line = mem_q[op_addr];
    merged = old_line;
    for (int b = 0; b < BE_W; b++)
      if (op_be[b]) merged[8*b +: 8] = op_wdata[8*b +: 8];

    upd_en      = '0;
    upd_state   = '{default: ST_I};
    upd_data_en = '0;
    upd_data    = old_line;
    rsp_data    = old_line;
    mem_we      = 1'b0;
    mem_wd      = lk_data[o];
    if (act && op_write) begin
      upd_en[g]      = 1'b1;
      upd_state[g]   = ST_M;
      upd_data_en[g] = 1'b1;
      upd_data       = merged;
      rsp_data       = merged;
      if (st_o != ST_I) begin
        upd_en[o]    = 1'b1;
        upd_state[o] = ST_I;
      end
      mem_we = (st_o == ST_M);
    end else if (act && st_g == ST_I) begin
      upd_en[g]      = 1'b1;
      upd_data_en[g] = 1'b1;
      upd_state[g]   = (st_o == ST_I) ? ST_E : ST_S;
      if (st_o == ST_E || st_o == ST_M) begin
        upd_en[o]    = 1'b1;
        upd_state[o] = ST_S;
      end
      mem_we = (st_o == ST_M);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
    end else if (mem_we) begin
      mem_q[op_addr] <= mem_wd;
    end
  end

  AST_SINGLE_OWNER0: assert property (@(posedge clk) disable iff (!rst_n)
    (act && (lk_state[0] == ST_M || lk_state[0] == ST_E)) |-> (lk_state[1] == ST_I)); // R10
  AST_SINGLE_OWNER1: assert property (@(posedge clk) disable iff (!rst_n)
    (act && (lk_state[1] == ST_M || lk_state[1] == ST_E)) |-> (lk_state[0] == ST_I)); // R10
endmodule

// File: rtl/mesi_coherence_ctrl.sv
module mesi_coherence_ctrl
  import mesi_coh_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                c0_req_valid,
  output logic                c0_req_ready,
  input  logic                c0_req_write,
  input  logic [ADDR_W-1:0]   c0_req_addr,
  input  logic [DATA_W-1:0]   c0_req_wdata,
  input  logic [DATA_W/8-1:0] c0_req_be,
  output logic                c0_rsp_valid,
  output logic [DATA_W-1:0]   c0_rsp_data,
  input  logic                c1_req_valid,
  output logic                c1_req_ready,
  input  logic                c1_req_write,
  input  logic [ADDR_W-1:0]   c1_req_addr,
  input  logic [DATA_W-1:0]   c1_req_wdata,
  input  logic [DATA_W/8-1:0] c1_req_be,
  output logic                c1_rsp_valid,
  output logic [DATA_W-1:0]   c1_rsp_data
);
  localparam int BE_W = DATA_W / 8;

  logic [1:0]             req, grant;
  logic                   sel, act;
  logic                   op_write;
  logic [ADDR_W-1:0]      op_addr;
  logic [DATA_W-1:0]      op_wdata;
  logic [BE_W-1:0]        op_be;
  line_st_t [1:0]         lk_state;
  logic [1:0][DATA_W-1:0] lk_data;
  logic [1:0]             upd_en, upd_data_en;
  line_st_t [1:0]         upd_state;
  logic [DATA_W-1:0]      upd_data, rsp_data_d, rsp_data_q;
  logic [1:0]             rsp_vld_d, rsp_vld_q;

  assign req = {c1_req_valid, c0_req_valid};

  mesi_rr_arb u_arb (.clk(clk), .rst_n(rst_n), .req(req), .grant(grant));

  always_comb begin
    sel      = grant[1];
    act      = |grant;
    op_write = sel ? c1_req_write : c0_req_write;
    op_addr  = sel ? c1_req_addr  : c0_req_addr;
    op_wdata = sel ? c1_req_wdata : c0_req_wdata;
    op_be    = sel ? c1_req_be    : c0_req_be;
  end

  for (genvar c = 0; c < 2; c++) begin : g_core
    mesi_priv_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cache (
      .clk(clk), .rst_n(rst_n), .lk_addr(op_addr),
      .lk_state(lk_state[c]), .lk_data(lk_data[c]),
      .upd_en(upd_en[c]), .upd_state(upd_state[c]),
      .upd_data_en(upd_data_en[c]), .upd_data(upd_data)
    );
  end

  mesi_home #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_home (
    .clk(clk), .rst_n(rst_n), .grant(grant), .op_write(op_write),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_be(op_be),
    .lk_state(lk_state), .lk_data(lk_data), .upd_en(upd_en),
    .upd_state(upd_state), .upd_data_en(upd_data_en),
    .upd_data(upd_data), .rsp_data(rsp_data_d)
  );

  assign rsp_vld_d = grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_vld_q <= '0;
    else        rsp_vld_q <= rsp_vld_d;
  end

  always_ff @(posedge clk) begin
    if (act) rsp_data_q <= rsp_data_d;
  end

  assign c0_req_ready = grant[0];
  assign c1_req_ready = grant[1];
  assign c0_rsp_valid = rsp_vld_q[0];
  assign c1_rsp_valid = rsp_vld_q[1];
  assign c0_rsp_data  = rsp_data_q;
  assign c1_rsp_data  = rsp_data_q;

  AST_RSP_AFTER_ACCEPT0: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_req_valid && c0_req_ready) |=> c0_rsp_valid); // R2
  AST_RSP_AFTER_ACCEPT1: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_req_valid && c1_req_ready) |=> c1_rsp_valid); // R2
  AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c1_rsp_valid, c0_rsp_valid})); // R2
  AST_LONE_REQ_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_req_valid && !c1_req_valid) |-> c0_req_ready); // R4
endmodule

// File: tb/mesi_coherence_ctrl_test.sv
`timescale 1ns/1ps
module mesi_coherence_ctrl_test;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int VW = 2 * (2 + AW + DW + BW);
  localparam int NV = 13;

  // per core: {valid, write, addr, data, be}; core 0 in the upper half
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,1'b0,3'd1,32'h0,4'h0,          1'b0,1'b0,3'd0,32'h0,4'h0},          // R1 load of fresh line
    {1'b1,1'b1,3'd1,32'h11223344,4'hF,   1'b0,1'b0,3'd0,32'h0,4'h0},          // R6
    {1'b0,1'b0,3'd0,32'h0,4'h0,          1'b1,1'b0,3'd1,32'h0,4'h0},          // R9 dirty peer
    {1'b0,1'b0,3'd0,32'h0,4'h0,          1'b1,1'b1,3'd1,32'hAABB00CC,4'h5},   // R5 sparse enables
    {1'b1,1'b0,3'd1,32'h0,4'h0,          1'b0,1'b0,3'd0,32'h0,4'h0},          // R7
    {1'b1,1'b1,3'd2,32'hDEAD0000,4'hF,   1'b1,1'b1,3'd2,32'h0000BEEF,4'hF},   // R3 R8 store race
    {1'b1,1'b0,3'd2,32'h0,4'h0,          1'b1,1'b0,3'd2,32'h0,4'h0},          // R3 R8 load race
    {1'b1,1'b1,3'd3,32'h1,4'hF,          1'b1,1'b1,3'd3,32'h2,4'hF},          // R8
    {1'b1,1'b0,3'd3,32'h0,4'h0,          1'b0,1'b0,3'd0,32'h0,4'h0},          // R8
    {1'b0,1'b0,3'd0,32'h0,4'h0,          1'b1,1'b0,3'd5,32'h0,4'h0},          // R11 exclusive fill
    {1'b0,1'b0,3'd0,32'h0,4'h0,          1'b1,1'b1,3'd5,32'h55,4'h1},         // R11 silent upgrade
    {1'b1,1'b0,3'd5,32'h0,4'h0,          1'b0,1'b0,3'd0,32'h0,4'h0},          // R11 peer sees store
    {1'b1,1'b1,3'd7,32'hFFFFFFFF,4'h8,   1'b1,1'b0,3'd6,32'h0,4'h0}           // R3 R5
  };

  logic clk, rst_n;
  logic          bv [2];
  logic          bw [2];
  logic [AW-1:0] ba [2];
  logic [DW-1:0] bd [2];
  logic [BW-1:0] bb [2];
  logic c0_ready, c1_ready, c0_rv, c1_rv;
  logic [DW-1:0] c0_rd, c1_rd;

  int errors, checks;
  logic [DW-1:0] model [1 << AW];
  logic prio_m;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  mesi_coherence_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .c0_req_valid(bv[0]), .c0_req_ready(c0_ready), .c0_req_write(bw[0]),
    .c0_req_addr(ba[0]), .c0_req_wdata(bd[0]), .c0_req_be(bb[0]),
    .c0_rsp_valid(c0_rv), .c0_rsp_data(c0_rd),
    .c1_req_valid(bv[1]), .c1_req_ready(c1_ready), .c1_req_write(bw[1]),
    .c1_req_addr(ba[1]), .c1_req_wdata(bd[1]), .c1_req_be(bb[1]),
    .c1_rsp_valid(c1_rv), .c1_rsp_data(c1_rd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_ports();
    for (int c = 0; c < 2; c++) begin
      bv[c] = 1'b0; bw[c] = 1'b0; ba[c] = '0; bd[c] = '0; bb[c] = '0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_ports();
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    prio_m = 1'b0;
    repeat (2) @(negedge clk);
    chk({c1_rv, c0_rv} == 2'b00, "R1", "rsp_valid in reset", {c1_rv, c0_rv}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input logic [VW-1:0] v);
    logic [1:0] pend, exp_rdy;
    int w;
    logic [DW-1:0] exp_d;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      logic [VW/2-1:0] h;
      h = (c == 0) ? v[VW-1:VW/2] : v[VW/2-1:0];
      {bv[c], bw[c], ba[c], bd[c], bb[c]} = h;
      pend[c] = bv[c];
    end
    while (pend != 2'b00) begin
      #0.5;
      if (pend == 2'b11) begin
        exp_rdy = prio_m ? 2'b10 : 2'b01;
        prio_m  = ~prio_m;
        chk({c1_ready, c0_ready} == exp_rdy, "R3", "tie-break ready", {c1_ready, c0_ready}, exp_rdy);
      end else begin
        exp_rdy = pend;
        chk({c1_ready, c0_ready} == exp_rdy, "R4", "lone ready", {c1_ready, c0_ready}, exp_rdy);
      end
      w = exp_rdy[1] ? 1 : 0;
      exp_d = model[ba[w]];
      if (bw[w]) begin
        for (int b = 0; b < BW; b++)
          if (bb[w][b]) exp_d[8*b +: 8] = bd[w][8*b +: 8];
        model[ba[w]] = exp_d;
      end
      @(negedge clk);
      chk({c1_rv, c0_rv} == exp_rdy, "R2", "rsp_valid", {c1_rv, c0_rv}, exp_rdy);
      chk(((w == 1) ? c1_rd : c0_rd) == exp_d,
          bw[w] ? "R5/R6/R8" : "R7/R8/R9", "rsp_data", (w == 1) ? c1_rd : c0_rd, exp_d);
      pend[w] = 1'b0;
      bv[w]   = 1'b0;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    errors = 0;
    checks = 0;
    rst_n  = 1'b0;
    idle_ports();
    do_reset();
    @(negedge clk);
    chk({c1_ready, c0_ready, c1_rv, c0_rv} == 4'b0, "R1", "idle after reset",
        {c1_ready, c0_ready, c1_rv, c0_rv}, 0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R1: a second reset clears the shared store and returns priority to core 0
    do_reset();
    run_vec({1'b1,1'b0,3'd2,32'h0,4'h0, 1'b1,1'b0,3'd3,32'h0,4'h0});
    // R5: all enables clear leaves the line unchanged
    run_vec({1'b1,1'b1,3'd4,32'h12345678,4'hF, 1'b0,1'b0,3'd0,32'h0,4'h0});
    run_vec({1'b0,1'b0,3'd0,32'h0,4'h0, 1'b1,1'b1,3'd4,32'hFFFFFFFF,4'h0});
    run_vec({1'b1,1'b0,3'd4,32'h0,4'h0, 1'b0,1'b0,3'd0,32'h0,4'h0});
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule